// File: doc/BRIEF.md
# No-Turnaround Late-Write Synchronous SRAM

A single-port synchronous RAM built from on-chip registers, whose data bus never needs an idle cycle when traffic changes direction. Every rising clock edge can accept a new read, a new write, a deselect, or a burst continuation. Write data does not arrive with its address: it follows one clock later in flow-through operation and two clocks later in pipelined operation. This delay matches the read latency of each mode, so reads and writes can share the bus at the full clock rate.

A static mode input picks the variant. Pipelined operation registers read data at the edge after the command and applies double late write. Flow-through operation drives read data combinationally during the cycle after the command and applies single late write. The control path keeps a short pipeline of write addresses and lane masks. A read that reaches a word whose write data is still in flight returns the merged data. Four-beat bursts are continued by an advance input, in linear or interleaved order. An asynchronous output enable can switch the bus drivers off at any time.

Top module: `zt_sram`

## Requirements
- R1: A command is accepted only when `ce1N` is 0, `ce2` is 1 and `ce3N` is 0 at the edge, or when `advance` is 1. In any other cycle no word is written and no read data is driven, whatever `weN` and `bwN` hold.
- R2: With `pipeMode` at 1, a read sampled at edge k drives its word on `dq` from edge k+1 until edge k+2.
- R3: With `pipeMode` at 1, a write sampled at edge k (`weN` = 0) takes its data from `dq` at edge k+2.
- R4: With `pipeMode` at 0, a read sampled at edge k drives its word on `dq` between edge k and edge k+1.
- R5: With `pipeMode` at 0, a write sampled at edge k takes its data from `dq` at edge k+1.
- R6: Any sequence of reads, writes, deselects and advances runs with one command per cycle and no inserted idle cycles. Each read returns the word as left by every write sampled before it, including writes whose data has not yet been committed.
- R7: Lane i is data bits [9i+8:9i]. A write changes lane i only when `bwN[i]` is 0, and lanes whose `bwN` bit is 1 keep their old contents. This also holds when a read picks up in-flight write data.
- R8: When `advance` is 1, the chip enables, `weN` and `addr` are ignored, and the previous operation continues at the next burst address. The upper address bits stay fixed. With `linBurstN` at 0, the low two bits at beat n are (base + n) mod 4. An advance after a deselect is itself a deselect.
- R9: With `linBurstN` at 1, the low two bits at beat n of a burst are base XOR n.
- R10: While `oeN` is 1, `dq` is not driven, taking effect without waiting for a clock edge. Pending read data reappears as soon as `oeN` returns to 0.
- R11: During and after a synchronous reset (`rstN` = 0), no command is pending and `dq` is not driven until a new read is accepted. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all sampling on the rising edge |
| rstN | input | 1 | Synchronous active-low reset of the command pipeline |
| pipeMode | input | 1 | Static: 1 pipelined with double late write, 0 flow-through with single late write |
| linBurstN | input | 1 | Static: 0 linear burst order, 1 interleaved |
| addr | input | ADDR_W | Word address |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| weN | input | 1 | 0 write, 1 read |
| advance | input | 1 | 1 continues the previous operation at the next burst address |
| bwN | input | BYTES | Per-lane write enables, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| dq | inout | BYTES*LANE_W | Shared data bus |

## Verification
The hardest case to reach is the pipelined read whose target word is also the target of the write issued one cycle before. That write's data is on the bus during the same edge that loads the read register, so only a partial-lane merge shows whether forwarding works. The stimulus creates this case with directed write-then-read pairs that use partial masks. A long random mix over sixteen addresses then produces many such collisions, together with advances that cross ignored chip enables. The reference model in the bench uses per-command due edges to track which writes precede each sampled read.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;

  // Strobes handed from control to datapath every cycle
  typedef struct packed {
    logic wrEn;    // commit a write at the coming edge
    logic rdLoad;  // command stage holds an accepted read
    logic fwdHit;  // committing write targets the word being read
    logic rdOn;    // output stage holds valid read data
  } sramStrobe_t;

  // Low address bits of burst beat 'step' starting from 'base'
  function automatic logic [1:0] burstLow(input logic [1:0] base,
                                          input logic [1:0] step,
                                          input logic       interleave);
    return interleave ? (base ^ step) : (base + step);
  endfunction

endpackage

// File: rtl/zt_sram_ctrl.sv
`timescale 1ns/1ps
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              linBurstN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              weN,
  input  logic              advance,
  input  logic [BYTES-1:0]  bwN,
  input  logic [ADDR_W-1:0] addr,
  output sramStrobe_t       strobe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTES-1:0]  wrMask
);

  localparam int HI_W = ADDR_W - 2;

  // command stage (edge k) and one-cycle-older write stage
  logic              cmdVld, cmdWr;
  logic [ADDR_W-1:0] cmdAddr;
  logic [BYTES-1:0]  cmdMask;
  logic              oldVld;
  logic [ADDR_W-1:0] oldAddr;
  logic [BYTES-1:0]  oldMask;
  logic              outVld;

  // burst bookkeeping
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        stepCnt;

  logic              chipSel;
  logic              nxtVld, nxtWr;
  logic [ADDR_W-1:0] nxtBase, nxtAddr;
  logic [1:0]        nxtStep;

  assign chipSel = !ce1N && ce2 && !ce3N;

  always_comb begin
    if (advance) begin
      nxtVld  = cmdVld;
      nxtWr   = cmdWr;
      nxtBase = baseAddr;
      nxtStep = stepCnt + 2'd1;
    end else begin
      nxtVld  = chipSel;
      nxtWr   = !weN;
      nxtBase = addr;
      nxtStep = 2'd0;
    end
    nxtAddr = {nxtBase[ADDR_W-1 -: HI_W], burstLow(nxtBase[1:0], nxtStep, linBurstN)};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdVld   <= 1'b0;
      cmdWr    <= 1'b0;
      cmdAddr  <= '0;
      cmdMask  <= '0;
      oldVld   <= 1'b0;
      oldAddr  <= '0;
      oldMask  <= '0;
      outVld   <= 1'b0;
      baseAddr <= '0;
      stepCnt  <= 2'd0;
    end else begin
      cmdVld   <= nxtVld;
      cmdWr    <= nxtWr;
      cmdAddr  <= nxtAddr;
      cmdMask  <= ~bwN;
      oldVld   <= cmdVld && cmdWr;
      oldAddr  <= cmdAddr;
      oldMask  <= cmdMask;
      outVld   <= cmdVld && !cmdWr;
      baseAddr <= nxtBase;
      stepCnt  <= nxtStep;
    end
  end

  always_comb begin
    strobe.wrEn   = pipeMode ? oldVld : (cmdVld && cmdWr);
    strobe.rdLoad = cmdVld && !cmdWr;
    strobe.fwdHit = pipeMode && oldVld && (oldAddr == cmdAddr);
    strobe.rdOn   = pipeMode ? outVld : (cmdVld && !cmdWr);
    wrAddr        = pipeMode ? oldAddr : cmdAddr;
    wrMask        = pipeMode ? oldMask : cmdMask;
    rdAddr        = cmdAddr;
  end

endmodule

// File: rtl/zt_sram_dpath.sv
`timescale 1ns/1ps
module zt_sram_dpath
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = BYTES * LANE_W
) (
  input  logic              clk,
  input  logic              pipeMode,
  input  sramStrobe_t       strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTES-1:0]  wrMask,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] arrWord, fwdWord, outReg;

  assign arrWord = memArr[rdAddr];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      for (int i = 0; i < BYTES; i++) begin
        if (wrMask[i]) memArr[wrAddr][i*LANE_W +: LANE_W] <= wrData[i*LANE_W +: LANE_W];
      end
    end
  end

  // per-lane merge of in-flight write data into the word being read
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign fwdWord[g*LANE_W +: LANE_W] = (strobe.fwdHit && wrMask[g])
                                         ? wrData[g*LANE_W +: LANE_W]
                                         : arrWord[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (strobe.rdLoad) outReg <= fwdWord;
  end

  assign rdData = pipeMode ? outReg : arrWord;

endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      pipeMode,
  input  logic                      linBurstN,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      ce1N,
  input  logic                      ce2,
  input  logic                      ce3N,
  input  logic                      weN,
  input  logic                      advance,
  input  logic [BYTES-1:0]          bwN,
  input  logic                      oeN,
  inout  wire  [BYTES*LANE_W-1:0]   dq
);

  localparam int DATA_W = BYTES * LANE_W;

  sramStrobe_t       strobe;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [BYTES-1:0]  wrMask;
  logic [DATA_W-1:0] rdData, wrData;
  logic              driveOn;

  zt_sram_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .linBurstN(linBurstN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .weN(weN), .advance(advance),
    .bwN(bwN), .addr(addr), .strobe(strobe), .rdAddr(rdAddr),
    .wrAddr(wrAddr), .wrMask(wrMask)
  );

  zt_sram_dpath #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LANE_W(LANE_W)) u_dpath (
    .clk(clk), .pipeMode(pipeMode), .strobe(strobe), .rdAddr(rdAddr),
    .wrAddr(wrAddr), .wrMask(wrMask), .wrData(wrData), .rdData(rdData)
  );

  assign driveOn = !oeN && strobe.rdOn;
  assign dq      = driveOn ? rdData : {DATA_W{1'bz}};
  assign wrData  = dq;

endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              pipeMode,
  input logic              linBurstN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              weN,
  input logic              advance,
  input logic [ADDR_W-1:0] addr,
  input sramStrobe_t       strobe,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [ADDR_W-1:0] wrAddr
);

  logic isDesel;
  logic isNewWrite;
  assign isDesel    = !advance && (ce1N || !ce2 || ce3N);
  assign isNewWrite = !advance && !ce1N && ce2 && !ce3N && !weN;

  p_desel_no_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    isDesel |=> !strobe.rdLoad);

  p_desel_no_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && isDesel) |=> !strobe.wrEn);

  p_pipe_read_out_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && strobe.rdLoad) |=> strobe.rdOn);

  p_pipe_write_late_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && isNewWrite) |=> ##1 (strobe.wrEn && wrAddr == $past(addr, 2)));

  p_flow_write_late_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && isNewWrite) |=> (strobe.wrEn && wrAddr == $past(addr)));

  p_lin_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!linBurstN && advance) |=>
      (rdAddr[1:0] == $past(rdAddr[1:0]) + 2'd1 &&
       rdAddr[ADDR_W-1:2] == $past(rdAddr[ADDR_W-1:2])));

endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .linBurstN(linBurstN),
  .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .weN(weN), .advance(advance),
  .addr(addr), .strobe(strobe), .rdAddr(rdAddr), .wrAddr(wrAddr)
);

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb;
  localparam int ADDR_W = 6;
  localparam int BYTES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = BYTES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rstN = 1'b0, pipeMode = 1'b1, linBurstN = 1'b0;
  logic ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1, weN = 1'b1, advance = 1'b0, oeN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [BYTES-1:0]  bwN = '1;
  logic              tbDrv = 1'b0;
  logic [DATA_W-1:0] tbData = '0;
  wire  [DATA_W-1:0] dq;

  assign dq = tbDrv ? tbData : {DATA_W{1'bz}};
  for (genvar i = 0; i < DATA_W; i++) begin : g_pu
    pullup pu (dq[i]);
  end

  zt_sram #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LANE_W(LANE_W)) u_dut (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .linBurstN(linBurstN),
    .addr(addr), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .weN(weN),
    .advance(advance), .bwN(bwN), .oeN(oeN), .dq(dq)
  );

  typedef struct {
    int                due;
    bit                isWr;
    int                adr;
    logic [BYTES-1:0]  mask;
    logic [DATA_W-1:0] data;
    int                tag;
    bit                oeOff;
  } pend_t;

  pend_t             pendQ[$];
  logic [DATA_W-1:0] model [DEPTH];
  int cycle = 0, checks = 0, fails = 0, idleTag = 11;
  int lastOp = 0, bBase = 0, bStep = 0;
  bit done = 1'b0;

  localparam logic [DATA_W-1:0] UNDRIVEN = '1;

  function automatic string tagName(int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";  4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic check(logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp, int tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", tagName(tag), cycle, act, exp);
    end
  endtask

  // op: 0 deselect, 1 read, 2 write, 3 advance. m is active-high lane mask.
  task automatic issue(int op, int a, logic [BYTES-1:0] m, logic [DATA_W-1:0] d,
                       int tag, bit oeOff);
    int    lat, kind, lo, eff;
    bit    seen;
    pend_t keep[$];
    pend_t e;
    lat = pipeMode ? 2 : 1;
    @(negedge clk);
    tbDrv = 1'b0;
    #0.5;
    seen = 1'b0;
    foreach (pendQ[i]) begin
      if (pendQ[i].due == cycle && !pendQ[i].isWr) begin
        seen = 1'b1;
        if (pendQ[i].oeOff) begin
          oeN = 1'b1; #0.3;
          check(dq, UNDRIVEN, 10);
          oeN = 1'b0; #0.3;
        end
        check(dq, model[pendQ[i].adr], pendQ[i].tag);
      end
    end
    if (!seen) check(dq, UNDRIVEN, idleTag);
    foreach (pendQ[i]) begin
      if (pendQ[i].due == cycle && pendQ[i].isWr) begin
        tbDrv  = 1'b1;
        tbData = pendQ[i].data;
        for (int b = 0; b < BYTES; b++)
          if (pendQ[i].mask[b])
            model[pendQ[i].adr][b*LANE_W +: LANE_W] = pendQ[i].data[b*LANE_W +: LANE_W];
      end else if (pendQ[i].due != cycle) begin
        keep.push_back(pendQ[i]);
      end
    end
    pendQ = keep;
    // reference burst model
    if (op == 3) begin
      bStep = (bStep + 1) % 4;
      kind  = lastOp;
    end else begin
      bBase = a;
      bStep = 0;
      kind  = op;
    end
    lo  = linBurstN ? ((bBase & 3) ^ bStep) : (((bBase & 3) + bStep) & 3);
    eff = (bBase & ~3) | lo;
    if (!rstN) begin
      kind = 0; bBase = 0; bStep = 0;
    end
    lastOp = kind;
    if (kind == 1 || kind == 2) begin
      e.due = cycle + lat; e.isWr = (kind == 2); e.adr = eff; e.mask = m;
      e.data = d; e.tag = tag; e.oeOff = oeOff;
      pendQ.push_back(e);
    end
    // drive the command for this edge
    addr    = ADDR_W'(a);
    advance = (op == 3);
    weN     = !(op == 2 || op == 0);
    bwN     = ~m;
    ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0;
    if (op == 0) begin
      case (a % 3)
        0: ce1N = 1'b1;
        1: ce2  = 1'b0;
        default: ce3N = 1'b1;
      endcase
    end
    if (op == 3) ce1N = 1'b1;   // enables ignored on advance
    cycle++;
  endtask

  function automatic logic [DATA_W-1:0] pat(int a);
    return DATA_W'(64'h5_A5A5_0000 + a * 64'h1_0203);
  endfunction

  function automatic logic [DATA_W-1:0] rnd();
    return DATA_W'({$urandom(), $urandom()});
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) issue(0, i, '1, rnd(), 1, 1'b0);
  endtask

  task automatic runMode(bit pm);
    int wrT, rdT, r;
    wrT = pm ? 3 : 5;
    rdT = pm ? 2 : 4;
    rstN = 1'b0; pipeMode = pm; linBurstN = 1'b0; idleTag = 11;
    idle(3);
    rstN = 1'b1;
    idle(2);
    idleTag = 1;
    // R3 / R5: full-rate fill, then R2 / R4 reads
    for (int a = 0; a < DEPTH; a++) issue(2, a, '1, pat(a), wrT, 1'b0);
    for (int a = 0; a < DEPTH; a += 5) issue(1, a, '0, '0, rdT, 1'b0);
    // R1: deselected write attempts leave words unchanged
    for (int k = 0; k < 3; k++) issue(0, 7 + k, '1, rnd(), 1, 1'b0);
    for (int k = 0; k < 3; k++) issue(1, 7 + k, '0, '0, 1, 1'b0);
    // R6: direction changes every cycle on the same word
    issue(2, 12, '1, 36'h1_2345_6789, 6, 1'b0);
    issue(1, 12, '0, '0, 6, 1'b0);
    issue(2, 12, '1, 36'h9_8765_4321, 6, 1'b0);
    issue(1, 12, '0, '0, 6, 1'b0);
    issue(1, 13, '0, '0, 6, 1'b0);
    issue(2, 13, '1, 36'hA_BCDE_F012, 6, 1'b0);
    issue(1, 13, '0, '0, 6, 1'b0);
    // R7: partial lanes, read directly behind the write
    issue(2, 20, 4'b0101, 36'hF_FFFF_FFFF, 7, 1'b0);
    issue(1, 20, '0, '0, 7, 1'b0);
    issue(2, 20, 4'b1000, 36'h0_0000_0000, 7, 1'b0);
    issue(1, 20, '0, '0, 7, 1'b0);
    issue(1, 20, '0, '0, 7, 1'b0);
    // R8: linear burst write and read from base 41
    issue(2, 41, '1, 36'h1_1111_1111, 8, 1'b0);
    for (int k = 0; k < 3; k++) issue(3, 0, '1, pat(100 + k), 8, 1'b0);
    issue(1, 41, '0, '0, 8, 1'b0);
    for (int k = 0; k < 3; k++) issue(3, 0, '0, '0, 8, 1'b0);
    // R8: advance after deselect does nothing
    issue(0, 50, '1, rnd(), 8, 1'b0);
    issue(3, 0, '1, rnd(), 8, 1'b0);
    issue(1, 51, '0, '0, 8, 1'b0);
    // R9: interleaved burst from base 45
    idle(3);
    linBurstN = 1'b1;
    idle(1);
    issue(2, 45, '1, 36'h2_2222_2222, 9, 1'b0);
    for (int k = 0; k < 3; k++) issue(3, 0, '1, pat(200 + k), 9, 1'b0);
    issue(1, 45, '0, '0, 9, 1'b0);
    for (int k = 0; k < 3; k++) issue(3, 0, '0, '0, 9, 1'b0);
    for (int k = 44; k < 48; k++) issue(1, k, '0, '0, 9, 1'b0);
    idle(3);
    linBurstN = 1'b0;
    idle(1);
    // R10: output enable pulled during a read's data window
    issue(1, 3, '0, '0, 10, 1'b1);
    issue(1, 4, '0, '0, 10, 1'b1);
    // R6: random mix with collisions over sixteen words
    for (int k = 0; k < 300; k++) begin
      r = $urandom % 10;
      if (r == 0)      issue(0, $urandom % 16, 4'($urandom), rnd(), 6, 1'b0);
      else if (r < 5)  issue(1, $urandom % 16, '0, '0, 6, 1'b0);
      else if (r < 9)  issue(2, $urandom % 16, 4'($urandom), rnd(), 6, 1'b0);
      else             issue(3, 0, 4'($urandom), rnd(), 6, 1'b0);
    end
    idle(4);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    runMode(1'b1);
    runMode(1'b0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule